// File: doc/BRIEF.md
# ISDN S/T Terminal Activation Controller

This block is the layer-1 activation and deactivation state machine for the terminal side of an ISDN S/T basic-rate interface. A receiver front end gives it decoded line indications: info 0, info 2, info 4, looped-back info 3, and a frame-lock flag. A host register interface gives it single-cycle command strobes, each carrying a 4-bit opcode. From these inputs the block chooses the info code the transmitter sends. It also drives a clock enable, a power-down flag and a 4-bit state code that the host can read.

Deactivation takes two steps. When info 0 arrives from the network, the machine parks in a pending state. It leaves that state only when the host sends a deactivate command. In the deactivated state, an internal microsecond timer delays the clock shutdown, and a configuration bit can disable the shutdown entirely. Host commands can also enter a test-pulse mode or an analog loop at any time. Line coding, framing and the D-channel are handled elsewhere.

Top module: `isdn_act_ctrl`

## Requirements
- R1: After rst, or one clock after a reset command (opcode 1) from any state, the state code is 0 (reset), tx_code is 0 (info 0), clk_en is 1 and pwr_down is 0.
- R2: In state 5 (unsynchronized) or 6 (activated), receiving info 0 (rx_ind 0) moves the machine to state 1 (pending deactivation) after one clock, with tx_code 0. In state 1, the activate command (opcode 4) and the timing command (opcode 2) have no effect.
- R3: A deactivate command (opcode 3) moves the machine from any state to state 2 (deactivated) after one clock. pwr_down is 1 exactly while the state code is 2.
- R4: In state 2, with cfg_clk_keep at 0 and info 0 received, clk_en falls to 0 SHUTDOWN_US × CLK_PER_US clocks after the clock that entered state 2, and not earlier. With cfg_clk_keep at 1, clk_en stays 1.
- R5: From state 2 or state 3, an activate command moves the machine to state 4 (pending activation), where tx_code is 1 (info 1). Receiving info 2 (rx_ind 1) in state 2 or state 3 moves it directly to state 5.
- R6: A timing command moves the machine to state 3 (power up) from any state except state 1. In state 3, tx_code is 0 and clk_en is 1.
- R7: State 4 holds while info 2 is absent. One clock after info 2 is received, the machine is in state 5 with tx_code 0.
- R8: In state 5, info 4 (rx_ind 2) with rx_lock at 1 enters state 6, where tx_code is 2 (info 3). In state 6, rx_lock at 0 returns the machine to state 5.
- R9: The single-pulse command (opcode 6) enters state 7, with tx_code 3. The continuous-pulse command (opcode 7) enters state 8, with tx_code 4. A timing or deactivate command leaves either test state.
- R10: The analog-loop command (opcode 5) enters state 9 (loop closed), with tx_code 2. Receiving looped info 3 (rx_ind 3) moves the machine to state 10 (loop activated). Losing info 3 returns it to state 9.
- R11: Opcodes 0 and 8 to 15 are ignored. When several command decodes are considered, the priority is reset, then analog loop and the test commands, then deactivate, then timing, then activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| rx_ind | input | 2 | Received line indication: 0 info 0, 1 info 2, 2 info 4, 3 info 3 |
| rx_lock | input | 1 | Receiver frame lock |
| cfg_clk_keep | input | 1 | 1 keeps clocks running in the deactivated state |
| tx_code | output | 3 | Transmit code: 0 info 0, 1 info 1, 2 info 3, 3 single pulse, 4 continuous pulse |
| clk_en | output | 1 | Clock enable for the interface clocks |
| pwr_down | output | 1 | Analog power-down request |
| state_code | output | 4 | Current state code |

## Verification
Every state change takes effect on the first clock edge after a command strobe or a line indication is presented. The outputs are decoded combinationally from the state register, so each check samples on the falling edge that follows that single edge. The clock shutdown is due exactly SHUTDOWN_US × CLK_PER_US edges after the edge that entered the deactivated state. The bench reduces CLK_PER_US, samples one edge before that count and again at the count, and so checks both sides of the boundary. Checks that a command is ignored read the state code and tx_code one edge after the strobe.

// File: rtl/isdn_act_pkg.sv
package isdn_act_pkg;

    typedef enum logic [3:0] {
        ST_RESET       = 4'd0,
        ST_PEND_DEACT  = 4'd1,
        ST_DEACT       = 4'd2,
        ST_POWER_UP    = 4'd3,
        ST_PEND_ACT    = 4'd4,
        ST_UNSYNC      = 4'd5,
        ST_ACTIVE      = 4'd6,
        ST_TEST_SINGLE = 4'd7,
        ST_TEST_CONT   = 4'd8,
        ST_LOOP_CLOSED = 4'd9,
        ST_LOOP_ACT    = 4'd10
    } act_state_e;

    localparam logic [3:0] OP_RES = 4'd1;
    localparam logic [3:0] OP_TIM = 4'd2;
    localparam logic [3:0] OP_DI  = 4'd3;
    localparam logic [3:0] OP_AR  = 4'd4;
    localparam logic [3:0] OP_ARL = 4'd5;
    localparam logic [3:0] OP_SSP = 4'd6;
    localparam logic [3:0] OP_SCP = 4'd7;

    localparam logic [1:0] RX_I0 = 2'd0;
    localparam logic [1:0] RX_I2 = 2'd1;
    localparam logic [1:0] RX_I4 = 2'd2;
    localparam logic [1:0] RX_I3 = 2'd3;

    typedef enum logic [2:0] {
        TX_I0     = 3'd0,
        TX_I1     = 3'd1,
        TX_I3     = 3'd2,
        TX_SPULSE = 3'd3,
        TX_CPULSE = 3'd4
    } tx_code_e;

    typedef struct packed {
        logic res;
        logic tim;
        logic di;
        logic ar;
        logic arl;
        logic ssp;
        logic scp;
    } act_cmd_t;

    function automatic tx_code_e tx_for_state(input act_state_e s);
        case (s)
            ST_PEND_ACT:    return TX_I1;
            ST_ACTIVE,
            ST_LOOP_CLOSED,
            ST_LOOP_ACT:    return TX_I3;
            ST_TEST_SINGLE: return TX_SPULSE;
            ST_TEST_CONT:   return TX_CPULSE;
            default:        return TX_I0;
        endcase
    endfunction

endpackage

// File: rtl/isdn_act_cmd_dec.sv
module isdn_act_cmd_dec
    import isdn_act_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    output act_cmd_t   cmd
);
    always_comb begin
        cmd = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_RES:  cmd.res = 1'b1;
                OP_TIM:  cmd.tim = 1'b1;
                OP_DI:   cmd.di  = 1'b1;
                OP_AR:   cmd.ar  = 1'b1;
                OP_ARL:  cmd.arl = 1'b1;
                OP_SSP:  cmd.ssp = 1'b1;
                OP_SCP:  cmd.scp = 1'b1;
                default: cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/isdn_act_shutdown_timer.sv
module isdn_act_shutdown_timer #(
    parameter int CLK_PER_US  = 50,
    parameter int SHUTDOWN_US = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int UW = $clog2(SHUTDOWN_US + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(CLK_PER_US - 1);
    localparam logic [UW-1:0] US_LIMIT  = UW'(SHUTDOWN_US);

    logic [TW-1:0] tick_q;
    logic [UW-1:0] us_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_q <= '0;
            us_q   <= '0;
        end else if (us_q != US_LIMIT) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                us_q   <= us_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign expired = (us_q == US_LIMIT);

    assert_us_bound_R4: assert property (@(posedge clk) disable iff (rst)
        us_q <= US_LIMIT);

    assert_stop_clears_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (us_q == '0) && (tick_q == '0));
endmodule

// File: rtl/isdn_act_fsm.sv
module isdn_act_fsm
    import isdn_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  act_cmd_t   cmd,
    input  logic [1:0] rx_ind,
    input  logic       rx_lock,
    output act_state_e state_q
);
    act_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (cmd.res)
            state_d = ST_RESET;
        else if (cmd.arl)
            state_d = ST_LOOP_CLOSED;
        else if (cmd.ssp)
            state_d = ST_TEST_SINGLE;
        else if (cmd.scp)
            state_d = ST_TEST_CONT;
        else if (cmd.di)
            state_d = ST_DEACT;
        else if (cmd.tim && state_q != ST_PEND_DEACT)
            state_d = ST_POWER_UP;
        else begin
            case (state_q)
                ST_DEACT, ST_POWER_UP: begin
                    if (cmd.ar)               state_d = ST_PEND_ACT;
                    else if (rx_ind == RX_I2) state_d = ST_UNSYNC;
                end
                ST_PEND_ACT:
                    if (rx_ind == RX_I2) state_d = ST_UNSYNC;
                ST_UNSYNC: begin
                    if (rx_ind == RX_I0)                 state_d = ST_PEND_DEACT;
                    else if (rx_ind == RX_I4 && rx_lock) state_d = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (rx_ind == RX_I0) state_d = ST_PEND_DEACT;
                    else if (!rx_lock)   state_d = ST_UNSYNC;
                end
                ST_LOOP_CLOSED:
                    if (rx_ind == RX_I3) state_d = ST_LOOP_ACT;
                ST_LOOP_ACT:
                    if (rx_ind != RX_I3) state_d = ST_LOOP_CLOSED;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RESET;
        else     state_q <= state_d;
    end

    assert_res_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        cmd.res |=> state_q == ST_RESET);

    assert_pend_deact_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND_DEACT) && !(cmd.res || cmd.di || cmd.arl || cmd.ssp || cmd.scp)
        |=> state_q == ST_PEND_DEACT);

    assert_active_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE) && ($past(state_q) != ST_ACTIVE)
        |-> $past(rx_ind == RX_I4 && rx_lock));

    assert_cmd_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));
endmodule

// File: rtl/isdn_act_ctrl.sv
module isdn_act_ctrl
    import isdn_act_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int SHUTDOWN_US = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic [1:0] rx_ind,
    input  logic       rx_lock,
    input  logic       cfg_clk_keep,
    output logic [2:0] tx_code,
    output logic       clk_en,
    output logic       pwr_down,
    output logic [3:0] state_code
);
    act_cmd_t   cmd;
    act_state_e state;
    logic       timer_run;
    logic       timer_done;

    isdn_act_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd       (cmd)
    );

    isdn_act_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .rx_ind  (rx_ind),
        .rx_lock (rx_lock),
        .state_q (state)
    );

    assign timer_run = (state == ST_DEACT) && (rx_ind == RX_I0) && !cfg_clk_keep;

    isdn_act_shutdown_timer #(
        .CLK_PER_US  (CLK_PER_US),
        .SHUTDOWN_US (SHUTDOWN_US)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (timer_run),
        .expired (timer_done)
    );

    assign tx_code    = tx_for_state(state);
    assign pwr_down   = (state == ST_DEACT);
    assign clk_en     = !((state == ST_DEACT) && timer_done);
    assign state_code = state;

    assert_clk_off_in_deact_R4: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> pwr_down);

    assert_di_enters_deact_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_DI |=> pwr_down);

    assert_keep_clocks_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_clk_keep && $past(cfg_clk_keep) |-> clk_en);
endmodule

// File: tb/test_isdn_act_ctrl.sv
module test_isdn_act_ctrl;
    localparam int CPU = 4;
    localparam int SDU = 500;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [1:0] rx_ind = 2'd0;
    logic       rx_lock = 1'b0;
    logic       cfg_clk_keep = 1'b0;
    logic [2:0] tx_code;
    logic       clk_en;
    logic       pwr_down;
    logic [3:0] state_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    isdn_act_ctrl #(.CLK_PER_US(CPU), .SHUTDOWN_US(SDU)) i_isdn_act_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .rx_ind(rx_ind), .rx_lock(rx_lock), .cfg_clk_keep(cfg_clk_keep),
        .tx_code(tx_code), .clk_en(clk_en), .pwr_down(pwr_down),
        .state_code(state_code)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input int st, input int tx);
        chk(req, "state_code", int'(state_code), st);
        chk(req, "tx_code", int'(tx_code), tx);
    endtask

    task automatic send(input logic [3:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 4'd0;
    endtask

    task automatic line(input logic [1:0] ind, input logic lock);
        @(negedge clk);
        rx_ind  = ind;
        rx_lock = lock;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk_st("R1", 0, 0);
        chk("R1", "clk_en", int'(clk_en), 1);
        chk("R1", "pwr_down", int'(pwr_down), 0);
    endtask

    task automatic t_line_path;
        send(4'd2);                  chk_st("R6", 3, 0);
        chk("R6", "clk_en", int'(clk_en), 1);
        line(2'd1, 1'b0);            chk_st("R5", 5, 0);
        line(2'd2, 1'b1);            chk_st("R8", 6, 2);
        line(2'd2, 1'b0);            chk_st("R8", 5, 0);
        line(2'd2, 1'b1);            chk_st("R8", 6, 2);
        line(2'd0, 1'b1);            chk_st("R2", 1, 0);
        send(4'd4);                  chk_st("R2", 1, 0);
        send(4'd2);                  chk_st("R2", 1, 0);
        send(4'd3);                  chk_st("R3", 2, 0);
        chk("R3", "pwr_down", int'(pwr_down), 1);
    endtask

    task automatic t_host_act;
        send(4'd4);                  chk_st("R5", 4, 1);
        chk("R3", "pwr_down", int'(pwr_down), 0);
        repeat (3) @(negedge clk);   chk_st("R7", 4, 1);
        line(2'd1, 1'b0);            chk_st("R7", 5, 0);
        send(4'd1);                  chk_st("R1", 0, 0);
        line(2'd0, 1'b0);
    endtask

    task automatic t_shutdown;
        cfg_clk_keep = 1'b0;
        send(4'd3);                  chk_st("R3", 2, 0);
        repeat (SDU * CPU - 1) @(negedge clk);
        chk("R4", "clk_en before limit", int'(clk_en), 1);
        @(negedge clk);
        chk("R4", "clk_en at limit", int'(clk_en), 0);
        send(4'd2);                  chk_st("R6", 3, 0);
        chk("R6", "clk_en", int'(clk_en), 1);
        cfg_clk_keep = 1'b1;
        send(4'd3);
        repeat (SDU * CPU + 50) @(negedge clk);
        chk("R4", "clk_en kept", int'(clk_en), 1);
        cfg_clk_keep = 1'b0;
    endtask

    task automatic t_test_modes;
        send(4'd6);                  chk_st("R9", 7, 3);
        send(4'd7);                  chk_st("R9", 8, 4);
        send(4'd2);                  chk_st("R9", 3, 0);
        send(4'd7);                  chk_st("R9", 8, 4);
        send(4'd3);                  chk_st("R9", 2, 0);
    endtask

    task automatic t_loop;
        send(4'd5);                  chk_st("R10", 9, 2);
        line(2'd3, 1'b0);            chk_st("R10", 10, 2);
        line(2'd0, 1'b0);            chk_st("R10", 9, 2);
        send(4'd3);                  chk_st("R10", 2, 0);
    endtask

    task automatic t_ignore;
        send(4'd2);                  chk_st("R6", 3, 0);
        send(4'd0);                  chk_st("R11", 3, 0);
        send(4'd9);                  chk_st("R11", 3, 0);
        send(4'd15);                 chk_st("R11", 3, 0);
        send(4'd6);                  chk_st("R11", 7, 3);
        send(4'd1);                  chk_st("R1", 0, 0);
        chk("R1", "clk_en", int'(clk_en), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_line_path();
        t_host_act();
        t_shutdown();
        t_test_modes();
        t_loop();
        t_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule